// File: doc/BRIEF.md
# Modem Control and Status with Loopback

This block sits between a host CPU and the handshake lines of a serial port. A small control register, written by the CPU, drives four active-low outputs: data-terminal-ready, request-to-send and two general-purpose user lines. Each pin is the inverse of its register bit, so a set bit pulls the pin low. A fifth control bit selects a diagnostic loopback. In loopback the four outputs are parked at their inactive (high) level. The status logic then sees the control bits in place of the external pins.

The four active-low modem inputs are clear-to-send, data-set-ready, ring and carrier-detect. They arrive asynchronously, so each one passes through a multi-flop synchroniser. The block then records the line levels and latches a change flag for each line. These go into an eight-bit status word. A read strobe from the CPU clears the change flags. While any change flag is set, an interrupt request is raised. Deciding between this request and other interrupt sources is left to logic outside the block.

Top module: `mdm_ctrl_status`

## Requirements
- R1: While reset is asserted and right after it, every modem output (dtr_n, rts_n, out1_n, out2_n) is high, status_rd is 0 and irq is 0.
- R2: When loopback is off, control bits 0, 1, 2 and 3 drive dtr_n, rts_n, out1_n and out2_n respectively. A 1 drives the pin low and a 0 drives it high, from the first clock edge after the write.
- R3: Status bits 4, 5, 6 and 7 report the active level (the inverted pin) of cts_n, dsr_n, ri_n and dcd_n respectively.
- R4: Status bits 0, 1 and 3 become 1 when clear-to-send, data-set-ready or carrier-detect (respectively) changes in either direction.
- R5: Status bit 2 becomes 1 only when the ring line goes from active to inactive (ri_n going low to high). Ring going active leaves bit 2 at 0.
- R6: A read strobe (rd_en high for one cycle) clears status bits 0 to 3 on that clock edge. Status bits 4 to 7 are not affected by the read.
- R7: If a change flag would be set on the same edge that a read clears the flags, that flag ends up set. The other flags are still cleared.
- R8: irq is 1 exactly when at least one of status bits 0 to 3 is 1.
- R9: When control bit 4 is 1, all four modem outputs are high. The status levels then come from the control bits: cts from bit 1, dsr from bit 0, ri from bit 2 and dcd from bit 3. The external input pins have no effect on status.
- R10: An external input change shows up in the status word exactly SYNC_STAGES+1 clock edges after it is applied, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 5 | Control register write data |
| rd_en | input | 1 | Status read strobe; clears change flags |
| status_rd | output | 8 | Status word: flags in bits 3:0, levels in bits 7:4 |
| irq | output | 1 | Modem-status interrupt request |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| out1_n | output | 1 | First user output, active low |
| out2_n | output | 1 | Second user output, active low |

## Verification
The bench instantiates the block with SYNC_STAGES set to 3 instead of the default 2. This lengthens the gap between a pin change and its status update, so the latency check can show that nothing appears one edge early. It also makes a gap of several cycles in which a read strobe can be placed on exactly the edge where a flag gets set. With the same deeper chain, the loopback rows show that pin activity stays hidden over a longer settling window.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  // control register layout
  localparam int CTRL_W = 5;
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;

  // modem input lines, in status order
  localparam int NLINES = 4;
  localparam int L_CTS  = 0;
  localparam int L_DSR  = 1;
  localparam int L_RI   = 2;
  localparam int L_DCD  = 3;

  localparam int STAT_W = 2 * NLINES;

  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } ctrl_t;

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = chain_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q[s] <= RST_VAL;
      end else begin
        chain_q[s] <= stage_d;
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_bits,
  output logic [NLINES-1:0] loop_act,
  output logic              loop_en,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d = ctrl_t'(wr_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  // pins idle high in loopback; otherwise inverse of register
  always_comb begin
    if (ctrl_q.loop) begin
      dtr_n  = 1'b1;
      rts_n  = 1'b1;
      out1_n = 1'b1;
      out2_n = 1'b1;
    end else begin
      dtr_n  = ~ctrl_q.dtr;
      rts_n  = ~ctrl_q.rts;
      out1_n = ~ctrl_q.out1;
      out2_n = ~ctrl_q.out2;
    end
  end

  // internal return path used in loopback
  always_comb begin
    loop_act        = '0;
    loop_act[L_CTS] = ctrl_q.rts;
    loop_act[L_DSR] = ctrl_q.dtr;
    loop_act[L_RI]  = ctrl_q.out1;
    loop_act[L_DCD] = ctrl_q.out2;
  end

  assign loop_en   = ctrl_q.loop;
  assign ctrl_bits = ctrl_q;

endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] ext_act,
  input  logic [NLINES-1:0] loop_act,
  input  logic              loop_en,
  input  logic              rd_en,
  output logic [STAT_W-1:0] status_o,
  output logic [NLINES-1:0] set_o,
  output logic              irq_o
);

  logic [NLINES-1:0] lvl_cur;
  logic [NLINES-1:0] lvl_q;
  logic [NLINES-1:0] flag_q;
  logic [NLINES-1:0] flag_d;

  assign lvl_cur = loop_en ? loop_act : ext_act;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    if (i == L_RI) begin : g_trail
      assign set_o[i] = lvl_q[i] & ~lvl_cur[i];
    end else begin : g_any
      assign set_o[i] = lvl_q[i] ^ lvl_cur[i];
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (rd_en) begin
      flag_d = '0;
    end
    flag_d = flag_d | set_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      flag_q <= '0;
    end else begin
      lvl_q  <= lvl_cur;
      flag_q <= flag_d;
    end
  end

  assign status_o = {lvl_q, flag_q};
  assign irq_o    = |flag_q;

endmodule

// File: rtl/mdm_ctrl_status.sv
module mdm_ctrl_status
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [STAT_W-1:0] status_rd,
  output logic              irq,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n
);

  logic [NLINES-1:0] pins_raw;
  logic [NLINES-1:0] pins_sync;
  logic [NLINES-1:0] ext_act;
  logic [NLINES-1:0] loop_act;
  logic [NLINES-1:0] set_vec;
  logic [CTRL_W-1:0] ctrl_bits;
  logic              loop_en;

  always_comb begin
    pins_raw        = '1;
    pins_raw[L_CTS] = cts_n;
    pins_raw[L_DSR] = dsr_n;
    pins_raw[L_RI]  = ri_n;
    pins_raw[L_DCD] = dcd_n;
  end

  mdm_sync #(
    .WIDTH   (NLINES),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({NLINES{1'b1}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_sync)
  );

  assign ext_act = ~pins_sync;

  mdm_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ctrl_bits (ctrl_bits),
    .loop_act  (loop_act),
    .loop_en   (loop_en),
    .dtr_n     (dtr_n),
    .rts_n     (rts_n),
    .out1_n    (out1_n),
    .out2_n    (out2_n)
  );

  mdm_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_act  (ext_act),
    .loop_act (loop_act),
    .loop_en  (loop_en),
    .rd_en    (rd_en),
    .status_o (status_rd),
    .set_o    (set_vec),
    .irq_o    (irq)
  );

endmodule

// File: rtl/mdm_ctrl_status_chk.sv
module mdm_ctrl_status_chk
  import mdm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [STAT_W-1:0] status_rd,
  input logic              irq,
  input logic              dtr_n,
  input logic              rts_n,
  input logic              out1_n,
  input logic              out2_n,
  input logic [CTRL_W-1:0] ctrl_bits,
  input logic [NLINES-1:0] set_vec
);

  logic [3:0] pins_out;
  assign pins_out = {out2_n, out1_n, rts_n, dtr_n};

  AST_IRQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|status_rd[3:0])); // R8

  AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_bits[C_LOOP] |-> pins_out == 4'hF); // R9

  AST_PIN_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_bits[C_LOOP] |-> pins_out == ~ctrl_bits[3:0]); // R2

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && set_vec == '0) |=> status_rd[3:0] == 4'h0); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> (status_rd[3:0] & $past(set_vec)) == $past(set_vec)); // R7

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (status_rd[3:0] & $past(status_rd[3:0])) == $past(status_rd[3:0])); // R4

  AST_LOOP_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_bits[C_LOOP] && $past(ctrl_bits[C_LOOP])) |->
      status_rd[7:4] == $past({ctrl_bits[C_OUT2], ctrl_bits[C_OUT1],
                               ctrl_bits[C_DTR], ctrl_bits[C_RTS]})); // R9

  AST_TERI_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_rd[2]) |-> (!status_rd[6] && $past(status_rd[6]))); // R5

endmodule

bind mdm_ctrl_status mdm_ctrl_status_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .status_rd (status_rd),
  .irq       (irq),
  .dtr_n     (dtr_n),
  .rts_n     (rts_n),
  .out1_n    (out1_n),
  .out2_n    (out2_n),
  .ctrl_bits (ctrl_bits),
  .set_vec   (set_vec)
);

// File: tb/mdm_ctrl_status_test.sv
`timescale 1ns/1ps
module mdm_ctrl_status_test;

  localparam int SYNC = 3;
  localparam int NVEC = 11;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [4:0] wr_data;
  logic       rd_en;
  logic [7:0] status_rd;
  logic       irq;
  logic [3:0] pins_n;   // {dcd_n, ri_n, dsr_n, cts_n}
  logic       dtr_n, rts_n, out1_n, out2_n;
  logic [3:0] outs;     // {out2_n, out1_n, rts_n, dtr_n}

  int checks;
  int failures;
  bit done;

  assign outs = {out2_n, out1_n, rts_n, dtr_n};

  mdm_ctrl_status #(.SYNC_STAGES(SYNC)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .status_rd (status_rd),
    .irq       (irq),
    .cts_n     (pins_n[0]),
    .dsr_n     (pins_n[1]),
    .ri_n      (pins_n[2]),
    .dcd_n     (pins_n[3]),
    .dtr_n     (dtr_n),
    .rts_n     (rts_n),
    .out1_n    (out1_n),
    .out2_n    (out2_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {ctrl[4:0], pins_n[3:0], expected levels status[7:4], expected outs}
  localparam logic [16:0] VECS [NVEC] = '{
    {5'b00000, 4'b1111, 4'b0000, 4'b1111},
    {5'b00001, 4'b1110, 4'b0001, 4'b1110},
    {5'b01010, 4'b0101, 4'b1010, 4'b0101},
    {5'b00111, 4'b0000, 4'b1111, 4'b1000},
    {5'b10000, 4'b0000, 4'b0000, 4'b1111},
    {5'b10010, 4'b0000, 4'b0001, 4'b1111},
    {5'b10001, 4'b0000, 4'b0010, 4'b1111},
    {5'b10100, 4'b0000, 4'b0100, 4'b1111},
    {5'b11000, 4'b0000, 4'b1000, 4'b1111},
    {5'b11111, 4'b1111, 4'b1111, 4'b1111},
    {5'b01111, 4'b1111, 4'b0000, 4'b0000}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] v);
    wr_en   = 1'b1;
    wr_data = v;
    tick(1);
    wr_en   = 1'b0;
  endtask

  task automatic do_read();
    rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0;
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    wr_data  = '0;
    rd_en    = 1'b0;
    pins_n   = 4'hF;
    tick(3);
    chk("R1 outs in reset", {4'h0, outs}, 8'h0F);
    chk("R1 status in reset", status_rd, 8'h00);
    rst_n = 1'b1;
    tick(1);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [16:0] v;
      v = VECS[i];
      pins_n = v[11:8];
      do_write(v[16:12]);
      tick(SYNC + 2);
      if (v[16]) begin
        chk("R9 loop levels", {4'h0, status_rd[7:4]}, {4'h0, v[7:4]});
        chk("R9 loop outs idle", {4'h0, outs}, {4'h0, v[3:0]});
      end else begin
        chk("R3 levels", {4'h0, status_rd[7:4]}, {4'h0, v[7:4]});
        chk("R2 outs", {4'h0, outs}, {4'h0, v[3:0]});
      end
      do_read();
    end

    // R2 timing: one edge after the write
    do_write(5'b00000);
    chk("R2 outs one edge after write", {4'h0, outs}, 8'h0F);
    pins_n = 4'hF;
    tick(SYNC + 3);
    do_read();
    chk("R6 status clear baseline", status_rd, 8'h00);

    // R10 latency, R4 set, R8 irq
    pins_n[0] = 1'b0;
    tick(SYNC);
    chk("R10 not early", {7'd0, status_rd[4]}, 8'h00);
    tick(1);
    chk("R10 cts level on time", {7'd0, status_rd[4]}, 8'h01);
    chk("R4 cts delta", {4'h0, status_rd[3:0]}, 8'h01);
    chk("R8 irq raised", {7'd0, irq}, 8'h01);

    // R6 read clear
    do_read();
    chk("R6 flags cleared", {4'h0, status_rd[3:0]}, 8'h00);
    chk("R6 level kept", {7'd0, status_rd[4]}, 8'h01);
    chk("R8 irq dropped", {7'd0, irq}, 8'h00);

    // R5 ring edges
    pins_n[2] = 1'b0;
    tick(SYNC + 1);
    chk("R5 ring level", {7'd0, status_rd[6]}, 8'h01);
    chk("R5 leading edge ignored", {7'd0, status_rd[2]}, 8'h00);
    pins_n[2] = 1'b1;
    tick(SYNC + 1);
    chk("R5 trailing edge flag", {7'd0, status_rd[2]}, 8'h01);
    do_read();

    // R7 set on same edge as read
    pins_n[1] = 1'b0;
    tick(SYNC + 1);
    chk("R4 dsr delta", {4'h0, status_rd[3:0]}, 8'h02);
    pins_n[3] = 1'b0;
    tick(SYNC);
    rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0;
    chk("R7 set beats read", {4'h0, status_rd[3:0]}, 8'h08);
    chk("R3 levels after R7", {4'h0, status_rd[7:4]}, 8'h0B);

    // R4 inactive-going changes
    do_read();
    pins_n = 4'hF;
    tick(SYNC + 1);
    chk("R4 falling deltas", {4'h0, status_rd[3:0]}, 8'h0B);

    // R1 asynchronous reset mid-run
    do_write(5'b01111);
    chk("R2 all outs low", {4'h0, outs}, 8'h00);
    rst_n = 1'b0;
    #1;
    chk("R1 outs on reset", {4'h0, outs}, 8'h0F);
    chk("R1 status on reset", status_rd, 8'h00);
    tick(1);
    rst_n = 1'b1;
    tick(1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule